// File: doc/BRIEF.md
# Multicast Hash Filter

This block sits on the receive side of an Ethernet MAC. It decides whether a frame whose destination address is a group (multicast) address should be kept. It watches the destination address arrive one byte per strobe and runs the Ethernet CRC-32 over those six bytes. From the CRC it picks one bit of a 64-bit hash table, and that bit becomes the accept decision. The table is held as two 32-bit words. Software loads it through a small write port, either replacing a whole word or OR-ing extra bits into it. A read port returns either word.

When the least significant bit of the first address byte is clear, the address is unicast. In that case the hash check does not apply: the block lowers the accept flag and raises a separate bypass flag. The decision appears one clock after the last address byte, together with a one-cycle valid pulse.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC starts at 0xFFFFFFFF. It takes each address byte least significant bit first, uses the reflected polynomial 0xEDB88320, and runs over the six bytes in arrival order. No final inversion is applied.
- R2: The hash is the CRC with bit i moved to bit 31-i. Hash bit 31 selects the table word (0 selects word 0). Hash bits 30:26 give the bit index within that word.
- R3: For a multicast address (bit 0 of the first byte is 1), `resAccept` equals the selected table bit and `resBypass` is 0.
- R4: For a unicast address (bit 0 of the first byte is 0), `resAccept` is 0 and `resBypass` is 1, whatever the table holds.
- R5: `resValid` is high for exactly the one cycle after the clock edge that takes the sixth address byte, and is low at all other times.
- R6: After reset both table words read 0 and `resValid` is 0.
- R7: A write with `tblWrSet` = 0 replaces the word selected by `tblWrSel` with `tblWrData`.
- R8: A write with `tblWrSet` = 1 ORs `tblWrData` into the selected word. Bits that were set stay set, and the other word is unchanged.
- R9: A byte with `addrFirst` = 1 always starts a new address, dropping any partly received one. A valid byte with `addrFirst` = 0 while no address is in progress is ignored and produces no result.
- R10: `tblRdData` shows the word selected by `tblRdSel`, including any write from the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrValid | input | 1 | Address byte strobe |
| addrFirst | input | 1 | Marks the first byte of a destination address |
| addrByte | input | 8 | Address byte, first byte first |
| tblWrEn | input | 1 | Table write enable |
| tblWrSet | input | 1 | 1: OR data into word, 0: replace word |
| tblWrSel | input | SEL_W (1) | Table word to write |
| tblWrData | input | WORD_W (32) | Write data |
| tblRdSel | input | SEL_W (1) | Table word to read |
| tblRdData | output | WORD_W (32) | Selected table word |
| resValid | output | 1 | Decision valid pulse |
| resAccept | output | 1 | Multicast address hit in table |
| resBypass | output | 1 | Address was not multicast |

## Verification
The bench builds the block with its default values: six address bytes and two 32-bit table words. With those values the whole 64-bit table can be swept. For each of the 64 table positions the bench loads a single-bit table and pushes 64 multicast addresses through. It checks that only the addresses whose independently computed hash lands on that position are accepted, so every word and bit index is exercised. Separate passes cover unicast bypass, set-mode accumulation through readback, and restart or stray-byte sequencing.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic crcInit;   // first byte: seed CRC, capture group bit
    logic crcStep;   // fold addrByte into the CRC
    logic lastByte;  // final byte: produce a decision
  } mhfStrobe_t;

endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrValid,
  input  logic       addrFirst,
  output mhfStrobe_t strobe
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  // 0 means idle; otherwise the number of bytes already taken
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    strobe = '0;
    if (addrValid) begin
      if (addrFirst) begin
        strobe.crcInit  = 1'b1;
        strobe.crcStep  = 1'b1;
        strobe.lastByte = (ADDR_BYTES == 1);
      end else if (byteCnt != '0) begin
        strobe.crcStep  = 1'b1;
        strobe.lastByte = (byteCnt == CNT_W'(ADDR_BYTES - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                byteCnt <= '0;
    else if (strobe.lastByte) byteCnt <= '0;
    else if (strobe.crcInit)  byteCnt <= CNT_W'(1);
    else if (strobe.crcStep)  byteCnt <= byteCnt + CNT_W'(1);
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt < CNT_W'(ADDR_BYTES));

  assert_idle_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastByte |=> byteCnt == '0);

  assert_stray_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrFirst && byteCnt == '0) |-> !strobe.crcStep);

endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int WORD_W    = 32,
  localparam int SEL_W    = $clog2(NUM_WORDS),
  localparam int IDX_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mhfStrobe_t        strobe,
  input  logic [7:0]        addrByte,
  input  logic              tblWrEn,
  input  logic              tblWrSet,
  input  logic [SEL_W-1:0]  tblWrSel,
  input  logic [WORD_W-1:0] tblWrData,
  input  logic [SEL_W-1:0]  tblRdSel,
  output logic [WORD_W-1:0] tblRdData,
  output logic              resValid,
  output logic              resAccept,
  output logic              resBypass
);

  localparam int HASH_W = SEL_W + IDX_W;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction

  logic [WORD_W-1:0] tbl [NUM_WORDS];
  logic [31:0]       crcReg, crcSeed, crcNext;
  logic              groupReg, groupNow;
  logic [HASH_W-1:0] hashTop;
  logic [SEL_W-1:0]  wordSel;
  logic [IDX_W-1:0]  bitSel;
  logic              hit;
  logic [WORD_W-1:0] wrOld;

  // table words, one write path per word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        tbl[w] <= '0;
      else if (tblWrEn && tblWrSel == SEL_W'(w))
        tbl[w] <= tblWrSet ? (tbl[w] | tblWrData) : tblWrData;
    end
  end

  assign tblRdData = tbl[tblRdSel];
  assign wrOld     = tbl[tblWrSel];

  // CRC accumulation
  assign crcSeed  = strobe.crcInit ? 32'hFFFF_FFFF : crcReg;
  assign crcNext  = crcByte(crcSeed, addrByte);
  assign groupNow = strobe.crcInit ? addrByte[0] : groupReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= '1;
      groupReg <= 1'b0;
    end else begin
      if (strobe.crcStep) crcReg   <= crcNext;
      if (strobe.crcInit) groupReg <= addrByte[0];
    end
  end

  // top hash bits of the bit-reversed CRC
  always_comb begin
    for (int i = 0; i < HASH_W; i++)
      hashTop[HASH_W-1-i] = crcNext[i];
  end

  assign wordSel = hashTop[HASH_W-1 -: SEL_W];
  assign bitSel  = hashTop[IDX_W-1:0];
  assign hit     = tbl[wordSel][bitSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resAccept <= 1'b0;
      resBypass <= 1'b0;
    end else begin
      resValid  <= strobe.lastByte;
      resAccept <= strobe.lastByte & groupNow & hit;
      resBypass <= strobe.lastByte & ~groupNow;
    end
  end

  assert_valid_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastByte |=> resValid);

  assert_valid_only_after_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lastByte |=> !resValid);

  assert_bypass_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    resBypass |-> (resValid && !resAccept));

  assert_accept_needs_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    resAccept |-> resValid);

  assert_set_keeps_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrEn && tblWrSet) |=> ((tbl[$past(tblWrSel)] & $past(wrOld)) == $past(wrOld)));

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_WORDS  = 2,
  parameter int WORD_W     = 32,
  localparam int SEL_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              addrFirst,
  input  logic [7:0]        addrByte,
  input  logic              tblWrEn,
  input  logic              tblWrSet,
  input  logic [SEL_W-1:0]  tblWrSel,
  input  logic [WORD_W-1:0] tblWrData,
  input  logic [SEL_W-1:0]  tblRdSel,
  output logic [WORD_W-1:0] tblRdData,
  output logic              resValid,
  output logic              resAccept,
  output logic              resBypass
);

  mhfStrobe_t strobe;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrValid(addrValid),
    .addrFirst(addrFirst),
    .strobe   (strobe)
  );

  mhf_datapath #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addrByte (addrByte),
    .tblWrEn  (tblWrEn),
    .tblWrSet (tblWrSet),
    .tblWrSel (tblWrSel),
    .tblWrData(tblWrData),
    .tblRdSel (tblRdSel),
    .tblRdData(tblRdData),
    .resValid (resValid),
    .resAccept(resAccept),
    .resBypass(resBypass)
  );

endmodule

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic        addrFirst = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        tblWrEn = 1'b0;
  logic        tblWrSet = 1'b0;
  logic [0:0]  tblWrSel = '0;
  logic [31:0] tblWrData = '0;
  logic [0:0]  tblRdSel = '0;
  logic [31:0] tblRdData;
  logic        resValid, resAccept, resBypass;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter uut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrFirst(addrFirst),
    .addrByte(addrByte), .tblWrEn(tblWrEn), .tblWrSet(tblWrSet),
    .tblWrSel(tblWrSel), .tblWrData(tblWrData), .tblRdSel(tblRdSel),
    .tblRdData(tblRdData), .resValid(resValid), .resAccept(resAccept),
    .resBypass(resBypass)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-serial model of the hash from R1/R2; returns {wordSel, bitIdx}
  function automatic logic [5:0] refPos(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] h;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int i = 0; i < 32; i++) h[31-i] = c[i];
    return {h[31], h[30:26]};
  endfunction

  function automatic logic [47:0] mkAddr(input int j, input bit mc);
    logic [47:0] a;
    for (int k = 0; k < 6; k++) a[8*k +: 8] = 8'((j * 37) + (k * 91) + 13 + (j >> 3) * k);
    a[0] = mc;
    return a;
  endfunction

  task automatic writeWord(input logic sel, input logic set, input logic [31:0] d);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSet = set; tblWrSel = sel; tblWrData = d;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic readWord(input logic sel, output logic [31:0] d);
    tblRdSel = sel;
    #1;
    d = tblRdData;
  endtask

  // sends bytes a[7:0] first; returns outputs sampled the cycle after the last byte
  task automatic sendAddr(input logic [47:0] a, output logic v, output logic acc, output logic byp);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addrValid = 1'b1; addrFirst = (k == 0); addrByte = a[8*k +: 8];
      if (k > 0) check(!resValid, "R5 early valid", 32'(resValid), 0);
    end
    @(negedge clk);
    addrValid = 1'b0; addrFirst = 1'b0;
    v = resValid; acc = resAccept; byp = resBypass;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, m0, m1;
    logic v, acc, byp;
    logic [47:0] a;
    logic [5:0] pos;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: reset state
    readWord(1'b0, rd); check(rd == 0, "R6 word0 reset", rd, 0);
    readWord(1'b1, rd); check(rd == 0, "R6 word1 reset", rd, 0);
    check(!resValid, "R6 valid reset", 32'(resValid), 0);

    // R1 R2 R3: sweep every table position against 64 multicast addresses
    for (int p = 0; p < 64; p++) begin
      writeWord(1'b0, 1'b0, (p < 32)  ? (32'd1 << p)        : 32'd0);
      writeWord(1'b1, 1'b0, (p >= 32) ? (32'd1 << (p - 32)) : 32'd0);
      for (int j = 0; j < 64; j++) begin
        a = mkAddr(j, 1'b1);
        pos = refPos(a);
        sendAddr(a, v, acc, byp);
        check(v == 1'b1, "R5 valid after sixth byte", 32'(v), 1);
        check(acc == (pos == 6'(p)), "R1 R2 R3 accept vs hash position", 32'(acc), 32'(pos == 6'(p)));
        check(byp == 1'b0, "R3 no bypass on multicast", 32'(byp), 0);
        @(negedge clk);
        check(!resValid, "R5 single-cycle valid", 32'(resValid), 0);
      end
    end

    // R4: unicast bypass with full table
    writeWord(1'b0, 1'b0, 32'hFFFF_FFFF);
    writeWord(1'b1, 1'b0, 32'hFFFF_FFFF);
    for (int j = 0; j < 16; j++) begin
      sendAddr(mkAddr(j, 1'b0), v, acc, byp);
      check(v && !acc && byp, "R4 unicast bypass", {29'd0, v, acc, byp}, 32'b101);
    end

    // R7: word replace
    writeWord(1'b0, 1'b0, 32'h1234_5678);
    readWord(1'b0, rd); check(rd == 32'h1234_5678, "R7 replace word0", rd, 32'h1234_5678);
    readWord(1'b1, rd); check(rd == 32'hFFFF_FFFF, "R10 word1 untouched", rd, 32'hFFFF_FFFF);
    writeWord(1'b0, 1'b0, 32'h0);
    writeWord(1'b1, 1'b0, 32'h0);

    // R8: set mode accumulates bits, one address at a time
    m0 = 0; m1 = 0;
    for (int j = 0; j < 20; j++) begin
      pos = refPos(mkAddr(j, 1'b1));
      writeWord(pos[5], 1'b1, 32'd1 << pos[4:0]);
      if (pos[5]) m1 |= 32'd1 << pos[4:0]; else m0 |= 32'd1 << pos[4:0];
      readWord(1'b0, rd); check(rd == m0, "R8 set-mode word0", rd, m0);
      readWord(1'b1, rd); check(rd == m1, "R8 set-mode word1", rd, m1);
    end
    for (int j = 0; j < 20; j++) begin
      sendAddr(mkAddr(j, 1'b1), v, acc, byp);
      check(acc == 1'b1, "R8 R3 added address accepted", 32'(acc), 1);
    end

    // R9: stray bytes while idle produce nothing
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addrValid = 1'b1; addrFirst = 1'b0; addrByte = 8'(k * 29 + 1);
      check(!resValid, "R9 stray byte ignored", 32'(resValid), 0);
    end
    @(negedge clk);
    addrValid = 1'b0;
    check(!resValid, "R9 stray byte ignored", 32'(resValid), 0);

    // R9: partial address dropped by restart
    writeWord(1'b0, 1'b0, 32'h0);
    writeWord(1'b1, 1'b0, 32'h0);
    a = mkAddr(5, 1'b1);
    pos = refPos(a);
    writeWord(pos[5], 1'b0, 32'd1 << pos[4:0]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addrValid = 1'b1; addrFirst = (k == 0); addrByte = 8'hA5 ^ 8'(k);
    end
    sendAddr(a, v, acc, byp);
    check(v && acc && !byp, "R9 restart takes new address", {29'd0, v, acc, byp}, 32'b110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule